// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block is the digital controller for one H-bridge winding. An external comparator reports when the sensed winding current has reached the reference level. The controller then switches off the conducting high-side switch. It keeps the low-side switch on so that the current can decay, and it holds that state for a fixed number of clock cycles. After that it starts the next conduction interval. The comparator is ignored for a short blanking window at the start of every conduction interval, so that switching transients cannot end an interval early.

A direction input picks which diagonal pair of switches conducts. A 2-bit level code chooses one of four current steps and is passed on, one cycle later, as the select code of the reference DAC. Code `00` makes the bridge coast, with all four switches off. Used together, direction and level give full-, half- and quarter-step sequences for a stepper winding, or forward, reverse and coast for a DC motor.

A fault input, an undervoltage-lockout input and an active-low sleep input each force every switch off. A fault flag output goes low while the fault or lockout input is active.

The control is a four-state machine:
- `ST_IDLE`: all switches are off.
- `ST_DEAD`: all switches are off for exactly one cycle before any diagonal is enabled.
- `ST_ON`: the source switch and the opposite sink switch conduct.
- `ST_OFF`: only the sink switch is on, for the fixed off-time.

The transitions are:
- IDLE→DEAD when nothing inhibits.
- DEAD→ON, or DEAD→IDLE if an inhibit appears.
- ON→OFF on a trip once blanking has expired.
- OFF→ON when the off-time expires.
- ON/OFF→DEAD when the direction changes.
- Any state→IDLE on an inhibit: fault, lockout, sleep or level `00`.

Top module: `trip_chopper`

## Requirements
- R1: While reset is asserted, all four gate enables are low, `dac_sel_o` is 0 and `fault_n_o` is high.
- R2: A conduction interval is always preceded by one all-off cycle. With `dir_i`=1 it drives `hs_a_o` and `ls_b_o` high. With `dir_i`=0 it drives `hs_b_o` and `ls_a_o` high.
- R3: A trip accepted in the on state turns off the source switch on the next cycle, and the sink switch of the same diagonal stays on.
- R4: `trip_i` is ignored during the first BLANK_CYC cycles of every conduction interval, including intervals that restart after an off-time.
- R5: The off state lasts exactly OFF_CYC cycles (OFF_CYC_FAST when FAST_OFF=1). The source switch of the same diagonal then turns on again.
- R6: When `dir_i` changes, all switches are off for at least one cycle before the other diagonal is enabled.
- R7: A level code of `00` turns all switches off from the next cycle, and no conduction interval starts while it is held.
- R8: While `fault_i` or `uvlo_i` is high, all switches are off from the next cycle. Operation resumes through the all-off cycle once both are low.
- R9: While `sleep_n_i` is low, all switches are off. On release, a new conduction interval starts with a full blanking window.
- R10: `fault_n_o` is low in the cycle after `fault_i` or `uvlo_i` is high, and high otherwise.
- R11: `dac_sel_o` equals the value that `level_i` had one cycle earlier.
- R12: The high-side and low-side enables of one bridge leg are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Direction: selects the conducting diagonal |
| level_i | input | 2 | Current step code, `00` = coast |
| trip_i | input | 1 | Comparator: current has reached the reference |
| fault_i | input | 1 | Over-temperature or gate-supply fault |
| uvlo_i | input | 1 | Undervoltage lockout active |
| sleep_n_i | input | 1 | Active-low sleep |
| hs_a_o | output | 1 | High-side enable, leg A |
| ls_a_o | output | 1 | Low-side enable, leg A |
| hs_b_o | output | 1 | High-side enable, leg B |
| ls_b_o | output | 1 | Low-side enable, leg B |
| dac_sel_o | output | 2 | Reference DAC select code |
| fault_n_o | output | 1 | Fault flag, low while fault or lockout is active |

## Verification
The hardest situation to reach is a trip that arrives exactly at the edge of the blanking window in an interval that restarted after an off-time. Both timers must then have run to their ends with no inhibit in between. Directed sequences hold the trip input high from the first cycle of an interval. They count the cycles until the source switch drops, once for a first interval, once for a restarted one and once after a sleep release. Random stimulus then mixes direction flips, coasting and faults at all points of the cycle, to test for dead time and shoot-through.

// File: rtl/chop_pkg.sv
package chop_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DEAD = 2'd1,
        ST_ON   = 2'd2,
        ST_OFF  = 2'd3
    } chop_state_t;
endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/chop_gate_map.sv
module chop_gate_map (
    input  logic drive_src,
    input  logic drive_snk,
    input  logic dir,
    output logic hs_a,
    output logic ls_a,
    output logic hs_b,
    output logic ls_b
);
    always_comb begin
        hs_a = drive_src && dir;
        ls_b = drive_snk && dir;
        hs_b = drive_src && !dir;
        ls_a = drive_snk && !dir;
    end
endmodule

// File: rtl/trip_chopper.sv
module trip_chopper
    import chop_pkg::*;
#(
    parameter int BLANK_CYC    = 125,
    parameter int OFF_CYC      = 3750,
    parameter int OFF_CYC_FAST = 1013,
    parameter bit FAST_OFF     = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dir_i,
    input  logic [1:0] level_i,
    input  logic       trip_i,
    input  logic       fault_i,
    input  logic       uvlo_i,
    input  logic       sleep_n_i,
    output logic       hs_a_o,
    output logic       ls_a_o,
    output logic       hs_b_o,
    output logic       ls_b_o,
    output logic [1:0] dac_sel_o,
    output logic       fault_n_o
);
    localparam int OFF_EFF = FAST_OFF ? OFF_CYC_FAST : OFF_CYC;
    localparam int TMAX    = (BLANK_CYC > OFF_EFF) ? BLANK_CYC : OFF_EFF;
    localparam int TW      = $clog2(TMAX + 1);
    localparam logic [TW-1:0] BLANK_LD = TW'(BLANK_CYC);
    localparam logic [TW-1:0] OFF_LD   = TW'(OFF_EFF - 1);

    chop_state_t state, nxt;
    logic        dir_q;
    logic        inhibit;
    logic        blank_done, off_done;
    logic        blank_load, off_load;
    logic        drive_src, drive_snk;

    assign inhibit = fault_i || uvlo_i || !sleep_n_i || (level_i == 2'b00);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            dir_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_DEAD && nxt == ST_ON)
                dir_q <= dir_i;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (!inhibit) nxt = ST_DEAD;
            ST_DEAD: nxt = inhibit ? ST_IDLE : ST_ON;
            ST_ON: begin
                if (inhibit)                  nxt = ST_IDLE;
                else if (dir_i != dir_q)      nxt = ST_DEAD;
                else if (trip_i && blank_done) nxt = ST_OFF;
            end
            ST_OFF: begin
                if (inhibit)             nxt = ST_IDLE;
                else if (dir_i != dir_q) nxt = ST_DEAD;
                else if (off_done)       nxt = ST_ON;
            end
        endcase
    end

    assign blank_load = (nxt == ST_ON)  && (state != ST_ON);
    assign off_load   = (nxt == ST_OFF) && (state != ST_OFF);

    chop_timer #(.W(TW)) u_blank (
        .clk(clk), .rst_n(rst_n), .load(blank_load),
        .load_val(BLANK_LD), .expired(blank_done)
    );

    chop_timer #(.W(TW)) u_off (
        .clk(clk), .rst_n(rst_n), .load(off_load),
        .load_val(OFF_LD), .expired(off_done)
    );

    // outputs
    always_comb begin
        drive_src = 1'b0;
        drive_snk = 1'b0;
        unique case (state)
            ST_IDLE, ST_DEAD: ;
            ST_ON:  begin drive_src = 1'b1; drive_snk = 1'b1; end
            ST_OFF: drive_snk = 1'b1;
        endcase
    end

    chop_gate_map u_map (
        .drive_src(drive_src), .drive_snk(drive_snk), .dir(dir_q),
        .hs_a(hs_a_o), .ls_a(ls_a_o), .hs_b(hs_b_o), .ls_b(ls_b_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_sel_o <= 2'b00;
            fault_n_o <= 1'b1;
        end else begin
            dac_sel_o <= level_i;
            fault_n_o <= !(fault_i || uvlo_i);
        end
    end
endmodule

// File: rtl/chop_checker.sv
module chop_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] level_i,
    input logic       fault_i,
    input logic       uvlo_i,
    input logic       sleep_n_i,
    input logic       hs_a_o,
    input logic       ls_a_o,
    input logic       hs_b_o,
    input logic       ls_b_o,
    input logic [1:0] dac_sel_o,
    input logic       fault_n_o
);
    logic any_on;
    assign any_on = hs_a_o || ls_a_o || hs_b_o || ls_b_o;

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_a_o && ls_a_o) && !(hs_b_o && ls_b_o)); // R12
    AST_DEAD_AB: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_a_o || ls_b_o) |=> !(hs_b_o || ls_a_o)); // R6
    AST_DEAD_BA: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_b_o || ls_a_o) |=> !(hs_a_o || ls_b_o)); // R6
    AST_COAST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i == 2'b00) |=> !any_on); // R7
    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_i || uvlo_i) |=> !any_on); // R8
    AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n_i |=> !any_on); // R9
    AST_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_i || uvlo_i) |=> !fault_n_o); // R10
    AST_DAC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dac_sel_o == $past(level_i))); // R11
endmodule

bind trip_chopper chop_checker u_chk (.*);

// File: tb/sim_trip_chopper.sv
`timescale 1ns/1ps
module sim_trip_chopper;
    localparam int BLANK = 4;
    localparam int OFFC  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_i = 1'b1;
    logic [1:0] level_i = 2'd3;
    logic trip_i = 1'b0, fault_i = 1'b0, uvlo_i = 1'b0, sleep_n_i = 1'b1;
    logic hs_a_o, ls_a_o, hs_b_o, ls_b_o, fault_n_o;
    logic [1:0] dac_sel_o;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    trip_chopper #(.BLANK_CYC(BLANK), .OFF_CYC(OFFC)) u0 (.*);

    // gate vector {hs_a, ls_a, hs_b, ls_b}
    function automatic logic [3:0] g_on(input logic d);
        return d ? 4'b1001 : 4'b0110;
    endfunction
    function automatic logic [3:0] g_hold(input logic d);
        return d ? 4'b0001 : 4'b0100;
    endfunction
    function automatic logic exp_flag(input logic f, input logic u);
        return !(f || u);
    endfunction

    function automatic logic [3:0] gates();
        return {hs_a_o, ls_a_o, hs_b_o, ls_b_o};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] pg;
        logic p_inh, p_f, p_u;
        logic [1:0] p_lv;
        void'($urandom(32'd4242));

        // R1 reset state
        step(); step();
        chk(gates(), 4'b0000, "R1 gates");
        chk(dac_sel_o, 2'd0, "R1 dac");
        chk(fault_n_o, 1'b1, "R1 flag");
        rst_n = 1'b1;

        // R2 dead cycle then diagonal A
        step(); chk(gates(), 4'b0000, "R2 dead");
        step(); chk(gates(), g_on(1), "R2 on dir1");
        chk(dac_sel_o, 2'd3, "R11 dac");

        // R4 blanking, R3 trip, R5 off-time
        trip_i = 1'b1;
        for (int i = 0; i < BLANK; i++) begin step(); chk(gates(), g_on(1), "R4 blank"); end
        step(); chk(gates(), g_hold(1), "R3 source off");
        trip_i = 1'b0;
        for (int i = 1; i < OFFC; i++) begin step(); chk(gates(), g_hold(1), "R5 off hold"); end
        step(); chk(gates(), g_on(1), "R5 reon");

        // R4 fresh blanking after restart
        trip_i = 1'b1;
        for (int i = 0; i < BLANK; i++) begin step(); chk(gates(), g_on(1), "R4 reblank"); end
        step(); chk(gates(), g_hold(1), "R3 second trip");
        trip_i = 1'b0;

        // R6 direction change during off
        dir_i = 1'b0;
        step(); chk(gates(), 4'b0000, "R6 dead");
        step(); chk(gates(), g_on(0), "R2 on dir0");

        // R7 coast
        level_i = 2'd0;
        for (int i = 0; i < 6; i++) begin step(); chk(gates(), 4'b0000, "R7 coast"); end
        level_i = 2'd2;
        step(); chk(gates(), 4'b0000, "R7 dead"); chk(dac_sel_o, 2'd2, "R11 dac2");
        step(); chk(gates(), g_on(0), "R7 resume");

        // R8 fault
        fault_i = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step(); chk(gates(), 4'b0000, "R8 fault off"); chk(fault_n_o, 1'b0, "R10 flag");
        end
        fault_i = 1'b0;
        step(); chk(gates(), 4'b0000, "R8 dead"); chk(fault_n_o, 1'b1, "R10 clear");
        step(); chk(gates(), g_on(0), "R8 resume");

        // R8 uvlo
        uvlo_i = 1'b1;
        step(); chk(gates(), 4'b0000, "R8 uvlo off"); chk(fault_n_o, 1'b0, "R10 uvlo");
        uvlo_i = 1'b0; dir_i = 1'b1;
        step(); chk(gates(), 4'b0000, "R8 uvlo dead");
        step(); chk(gates(), g_on(1), "R8 uvlo resume");

        // R9 sleep, fresh blanking on release
        trip_i = 1'b1; sleep_n_i = 1'b0;
        for (int i = 0; i < 3; i++) begin step(); chk(gates(), 4'b0000, "R9 sleep"); end
        sleep_n_i = 1'b1;
        step(); chk(gates(), 4'b0000, "R9 dead");
        step(); chk(gates(), g_on(1), "R9 on");
        for (int i = 0; i < BLANK; i++) begin step(); chk(gates(), g_on(1), "R9 blank"); end
        step(); chk(gates(), g_hold(1), "R9 trip");
        trip_i = 1'b0;

        // random phase
        pg = gates();
        for (int n = 0; n < 4000; n++) begin
            fault_i   = ($urandom % 40) == 0;
            uvlo_i    = ($urandom % 60) == 0;
            sleep_n_i = ($urandom % 50) != 0;
            if (($urandom % 8) == 0) level_i = 2'($urandom % 4);
            if (($urandom % 20) == 0) dir_i = ~dir_i;
            trip_i = ($urandom % 3) == 0;
            p_inh = fault_i || uvlo_i || !sleep_n_i || (level_i == 2'd0);
            p_f = fault_i; p_u = uvlo_i; p_lv = level_i;
            step();
            chk((hs_a_o && ls_a_o) || (hs_b_o && ls_b_o), 1'b0, "R12 shoot");
            if (p_inh) chk(gates(), 4'b0000, "R8 R9 R7 inhibit");
            chk(fault_n_o, exp_flag(p_f, p_u), "R10 rand");
            chk(dac_sel_o, p_lv, "R11 rand");
            chk((pg[3] || pg[0]) && (gates()[1] || gates()[2]), 1'b0, "R6 AB");
            chk((pg[1] || pg[2]) && (gates()[3] || gates()[0]), 1'b0, "R6 BA");
            pg = gates();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule